// File: doc/BRIEF.md
# Set-on-less-than comparison unit

This block decides whether a first 32-bit operand is smaller than a second one and returns the answer as a 32-bit word. The word is 1 when the first operand is smaller and 0 otherwise. The second operand is either a second 32-bit register value or a 16-bit immediate. Two select bits choose the source of the second operand and whether the ordering is signed or unsigned. That gives four variants: register/signed, register/unsigned, immediate/signed and immediate/unsigned.

The immediate is always sign-extended to 32 bits, and this includes the unsigned variant. For example, an immediate of 0x8000 becomes 0xFFFF8000, and that value is then compared as a plain magnitude.

The block is purely combinational. It is meant to sit next to an equal/not-equal branch unit. To branch on less-than, a pipeline writes this block's result into a scratch register and then branches when that register differs from zero.

Top module: `slt_unit`

## Requirements
- R1: `slt_o[31:1]` is always zero. `slt_o[0]` is 1 exactly when the first operand is less than the selected second operand.
- R2: With `imm_sel_i`=0 and `signed_sel_i`=1, operands are ordered as two's-complement numbers. For example, 0xFFFFFFFF vs 0x00000001 gives 1.
- R3: With `imm_sel_i`=0 and `signed_sel_i`=0, operands are ordered by unsigned magnitude. For example, 0xFFFFFFFF vs 0x00000001 gives 0.
- R4: With `imm_sel_i`=1, the second operand is `imm_i` sign-extended from bit 15 to 32 bits, and `opb_i` has no effect on `slt_o`.
- R5: With `imm_sel_i`=1 and `signed_sel_i`=0, the sign-extended immediate is compared as an unsigned magnitude. For example, `opa_i`=0x7FFFFFFF with `imm_i`=0x8000 gives 1, because 0x7FFFFFFF < 0xFFFF8000.
- R6: When the first operand equals the selected second operand, `slt_o` is 0 in all four variants.
- R7: With `imm_sel_i`=0, `imm_i` has no effect on `slt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand (the left side of the less-than) |
| opb_i | input | 32 | Second register operand, used when `imm_sel_i`=0 |
| imm_i | input | 16 | Immediate, sign-extended and used when `imm_sel_i`=1 |
| imm_sel_i | input | 1 | 1 selects the immediate, 0 selects `opb_i` |
| signed_sel_i | input | 1 | 1 selects two's-complement ordering, 0 selects unsigned ordering |
| slt_o | output | 32 | Comparison result, 1 or 0 zero-extended |

## Verification
On every evaluation, the assertions check the following:
- The upper result bits stay zero.
- The sign extension of the immediate is correct.
- The chunked comparator never reports "less" and "equal" together.
- The result agrees with a direct signed or unsigned relation on the selected operands.

Only the bench's sweeps can show two kinds of behaviour. The first is that an unselected input (`opb_i` in immediate mode, `imm_i` in register mode) truly has no effect on the output. The second is that the boundary values 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and the immediates 0x7FFF and 0x8000, order correctly in each of the four variants.

// File: rtl/slt_pkg.sv
package slt_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned CHUNK_W = 8;

    typedef struct packed {
        logic use_imm;
        logic is_signed;
    } slt_mode_t;

endpackage

// File: rtl/slt_opsel.sv
module slt_opsel #(
    parameter int unsigned DATA_W = slt_pkg::DATA_W,
    parameter int unsigned IMM_W  = slt_pkg::IMM_W
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  slt_pkg::slt_mode_t mode_i,
    output logic [DATA_W-1:0] rhs_o,
    output logic [DATA_W-1:0] cmp_a_o,
    output logic [DATA_W-1:0] cmp_b_o
);

    localparam int unsigned EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] rhs;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } opsel_t;

    opsel_t sel_d;
    logic [DATA_W-1:0] imm_ext_d;

    always_comb begin
        imm_ext_d = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        sel_d.rhs = mode_i.use_imm ? imm_ext_d : opb_i;
        // Flipping the sign bit maps two's-complement order onto unsigned order.
        sel_d.a   = opa_i;
        sel_d.b   = sel_d.rhs;
        if (mode_i.is_signed) begin
            sel_d.a[DATA_W-1] = ~opa_i[DATA_W-1];
            sel_d.b[DATA_W-1] = ~sel_d.rhs[DATA_W-1];
        end
    end

    assign rhs_o   = sel_d.rhs;
    assign cmp_a_o = sel_d.a;
    assign cmp_b_o = sel_d.b;

    always_comb begin
        if (mode_i.use_imm) begin
            AST_IMM_SIGN_FILL: assert (rhs_o[DATA_W-1:IMM_W] == {EXT_W{imm_i[IMM_W-1]}}) // R4
                else $error("upper bits of immediate not sign fill");
            AST_IMM_LOW_BITS: assert (rhs_o[IMM_W-1:0] == imm_i) // R5
                else $error("immediate low bits altered");
        end
    end

endmodule

// File: rtl/slt_magcmp.sv
module slt_magcmp #(
    parameter int unsigned DATA_W  = slt_pkg::DATA_W,
    parameter int unsigned CHUNK_W = slt_pkg::CHUNK_W
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic              lt_o,
    output logic              eq_o
);

    localparam int unsigned NCHUNK = DATA_W / CHUNK_W;

    logic [NCHUNK-1:0] lt_c_d;
    logic [NCHUNK-1:0] eq_c_d;
    logic [NCHUNK-1:0] chain_lt_d;

    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        always_comb begin
            lt_c_d[g] = x_i[g*CHUNK_W +: CHUNK_W] < y_i[g*CHUNK_W +: CHUNK_W];
            eq_c_d[g] = x_i[g*CHUNK_W +: CHUNK_W] == y_i[g*CHUNK_W +: CHUNK_W];
        end
        if (g == 0) begin : g_first
            assign chain_lt_d[g] = lt_c_d[g];
        end else begin : g_rest
            // A higher chunk decides unless it ties, then the lower result stands.
            assign chain_lt_d[g] = lt_c_d[g] | (eq_c_d[g] & chain_lt_d[g-1]);
        end
    end

    assign lt_o = chain_lt_d[NCHUNK-1];
    assign eq_o = &eq_c_d;

    always_comb begin
        AST_LT_EQ_EXCL: assert (!(lt_o && eq_o)) // R6
            else $error("less and equal both reported");
        if (eq_o) begin
            AST_EQ_MATCH: assert (x_i == y_i) // R6
                else $error("equal flag on differing operands");
        end
    end

endmodule

// File: rtl/slt_unit.sv
module slt_unit #(
    parameter int unsigned DATA_W  = slt_pkg::DATA_W,
    parameter int unsigned IMM_W   = slt_pkg::IMM_W,
    parameter int unsigned CHUNK_W = slt_pkg::CHUNK_W
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              imm_sel_i,
    input  logic              signed_sel_i,
    output logic [DATA_W-1:0] slt_o
);

    slt_pkg::slt_mode_t mode_d;
    logic [DATA_W-1:0]  rhs_d;
    logic [DATA_W-1:0]  cmp_a_d;
    logic [DATA_W-1:0]  cmp_b_d;
    logic               lt_d;
    logic               eq_d;

    always_comb begin
        mode_d.use_imm   = imm_sel_i;
        mode_d.is_signed = signed_sel_i;
    end

    slt_opsel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_opsel (
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .imm_i   (imm_i),
        .mode_i  (mode_d),
        .rhs_o   (rhs_d),
        .cmp_a_o (cmp_a_d),
        .cmp_b_o (cmp_b_d)
    );

    slt_magcmp #(
        .DATA_W  (DATA_W),
        .CHUNK_W (CHUNK_W)
    ) u_magcmp (
        .x_i  (cmp_a_d),
        .y_i  (cmp_b_d),
        .lt_o (lt_d),
        .eq_o (eq_d)
    );

    always_comb begin
        slt_o    = '0;
        slt_o[0] = lt_d;
    end

    always_comb begin
        AST_UPPER_ZERO: assert (slt_o[DATA_W-1:1] == '0) // R1
            else $error("result upper bits nonzero");
        if (signed_sel_i) begin
            AST_SIGNED_ORDER: assert (slt_o[0] == ($signed(opa_i) < $signed(rhs_d))) // R2
                else $error("signed ordering mismatch");
        end else begin
            AST_UNSIGNED_ORDER: assert (slt_o[0] == (opa_i < rhs_d)) // R3
                else $error("unsigned ordering mismatch");
        end
        if (opa_i == rhs_d) begin
            AST_EQUAL_ZERO: assert (slt_o == '0) // R6
                else $error("equal operands gave nonzero");
        end
        if (!eq_d && !lt_d) begin
            AST_GREATER_ZERO: assert (slt_o[0] == 1'b0) // R1
                else $error("greater case gave one");
        end
    end

endmodule

// File: tb/slt_unit_bench.sv
module slt_unit_bench;

    logic        clk = 1'b0;
    logic [31:0] opa, opb;
    logic [15:0] imm;
    logic        imm_sel, signed_sel;
    logic [31:0] slt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    slt_unit u_slt_unit (
        .opa_i        (opa),
        .opb_i        (opb),
        .imm_i        (imm),
        .imm_sel_i    (imm_sel),
        .signed_sel_i (signed_sel),
        .slt_o        (slt)
    );

    function automatic logic [31:0] ref_slt(input logic [31:0] a, input logic [31:0] b,
                                            input logic sgn);
        logic [32:0] diff;
        if (sgn) diff = {a[31], a} - {b[31], b};
        else     diff = {1'b0, a} - {1'b0, b};
        return {31'd0, diff[32]};
    endfunction

    task automatic apply_check(input logic [31:0] a, input logic [31:0] b,
                               input logic [15:0] im, input logic isel,
                               input logic sgn, input string req);
        logic [31:0] rhs, exp;
        @(negedge clk);
        opa = a; opb = b; imm = im; imm_sel = isel; signed_sel = sgn;
        #1;
        rhs = isel ? {{16{im[15]}}, im} : b;
        exp = ref_slt(a, rhs, sgn);
        total++;
        if (slt !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h imm=%h isel=%0d sgn=%0d actual=%h expected=%h",
                     req, a, b, im, isel, sgn, slt, exp);
        end
    endtask

    logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h1234_5678};
    logic [15:0] imms [6] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFFE};

    initial begin
        opa = '0; opb = '0; imm = '0; imm_sel = 1'b0; signed_sel = 1'b0;
        #1;
        total++;
        if (slt !== 32'd0) begin
            bad++;
            $display("FAIL R6 initial all-zero inputs actual=%h expected=%h", slt, 32'd0);
        end

        // Named corner cases
        apply_check(32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b1, "R2");
        apply_check(32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, "R3");
        apply_check(32'h7FFF_FFFF, 32'h0, 16'h8000, 1'b1, 1'b0, "R5");
        apply_check(32'h7FFF_FFFF, 32'h0, 16'h8000, 1'b1, 1'b1, "R4");
        apply_check(32'hFFFF_8000, 32'h0, 16'h8000, 1'b1, 1'b0, "R6");

        // Register-mode sweep; the immediate is driven with junk (R7)
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    apply_check(vals[i], vals[j], ~vals[j][15:0] ^ 16'h8001, 1'b0, s[0],
                                (i == j) ? "R6" : (s == 1 ? "R2/R7" : "R3/R7"));

        // Immediate-mode sweep; opb carries junk that must be ignored (R4, R5)
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 6; i++)
                for (int k = 0; k < 6; k++)
                    apply_check(vals[i], ~vals[i] ^ {16'h0, imms[k]}, imms[k], 1'b1, s[0],
                                s == 1 ? "R4" : "R5");

        // Same a/imm with opposite opb extremes must agree (R4)
        apply_check(32'h0000_0005, 32'h0, 16'h0004, 1'b1, 1'b0, "R4");
        apply_check(32'h0000_0005, 32'hFFFF_FFFF, 16'h0004, 1'b1, 1'b0, "R4");
        // Upper result bits zero whenever the result is one (R1)
        apply_check(32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b1, "R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule